// File: doc/BRIEF.md
# Serial Controller Run-State Sequencer

This block owns the operational state of a serial peripheral. A host register port writes a two-bit state code and reads back the current code together with a settled flag. Every accepted request keeps the flag low for a programmable number of core-clock cycles. When that time has elapsed the new state takes effect and the flag rises again. The host must wait for the flag before it issues the next request. A typical transfer goes through these steps: load the configuration while in reset, go to run, pause, preload the output FIFO, then run again.

Leaving pause for reset uses a guarded path. The host must write the clear code twice before the block returns to reset. A single write of the reset code from pause is refused. A separate soft-reset register forces the block back to reset at once. The block drives an enable for the transfer datapath. It also pulses a flush strobe that empties the FIFOs and clears the transfer counters whenever reset takes effect.

Top module: `rs_run_sequencer`

## Requirements
- R1: After `rst_ni` is released, the block reads state 0 (reset) with valid high, the status register reads zero, and `dp_en_o` and `flush_o` are low.
- R2: The register map is fixed. Address 0 is the state register: bits [1:0] hold the state (0 reset, 1 run, 3 pause) and bit 2 holds the read-only valid flag. Address 1 is the write-only soft-reset register and reads as zero. Address 2 is the status register: bit 0 is the sticky illegal-request flag and bit 1 is the pending-clear flag. All other bits read zero.
- R3: An accepted state write of code 0, 1 or 3 drives valid low from the next cycle for N cycles, where N is `settle_i`. In the cycle valid rises, the state output takes the written code. Until then the state output keeps its old value.
- R4: A state write that arrives while valid is low is ignored and sets the sticky illegal flag.
- R5: In pause, the first write of code 2 sets the pending-clear flag and changes nothing else (valid stays high). A second write of 2 while the flag is set starts a settled transition to reset and clears the flag.
- R6: In pause, a write of code 0 is ignored (state stays pause, valid stays high) and cancels a pending clear. A write of 1 or 3 also cancels the pending clear and starts a normal transition.
- R7: A write of code 2 in any state other than pause has no effect.
- R8: Writing 1 in bit 0 of the soft-reset register makes the next cycle read state reset with valid high. It also clears the illegal and pending-clear flags and aborts any settle in progress. Writing 0 in bit 0 has no effect.
- R9: `flush_o` is a one-cycle pulse in the first cycle that the state reads reset after entering it, whether through a settled transition or a soft reset. It is low at all other times.
- R10: `dp_en_o` is high exactly when the state is run and valid is high.
- R11: A `settle_i` of 0 behaves as 1: valid stays low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| settle_i | input | SETTLE_W | Settle length in cycles (0 is treated as 1) |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W | Write address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_raddr_i | input | ADDR_W | Read address |
| reg_rdata_o | output | DATA_W | Read data, combinational from the read address |
| state_o | output | 2 | Current state code |
| valid_o | output | 1 | State settled; new requests are accepted |
| dp_en_o | output | 1 | Transfer datapath enable |
| flush_o | output | 1 | FIFO flush and counter clear pulse |

## Verification
The bench builds the block with SETTLE_W=4, ADDR_W=2 and DATA_W=32. With this narrow settle field, both the zero-length case and the longest settle of 15 cycles are cheap to reach. The two-bit address space lets random traffic hit every register, including the unmapped one. The random phase draws settle values from 0 to 3. This keeps the windows short, so many writes land while valid is low and interleavings of clear codes in pause come up often. Directed sequences cover soft reset during a 15-cycle settle and the pause exit paths.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_CLEAR = 2'd2,
    ST_PAUSE = 2'd3
  } run_state_e;
endpackage

// File: rtl/rs_settle_timer.sv
module rs_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_eff;

  assign len_eff = (len_i == '0) ? CNT_W'(1) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (abort_i)         cnt_q <= '0;
    else if (start_i)         cnt_q <= len_eff;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1)) && !abort_i;

  // R3
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !abort_i && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R11
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> busy_o);
endmodule

// File: rtl/rs_req_decode.sv
module rs_req_decode
  import rs_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_STATE = 0,
  parameter int ADDR_SRST  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              valid_i,
  input  run_state_e        cur_state_i,
  output logic              start_o,
  output run_state_e        target_o,
  output logic              illegal_o,
  output logic              srst_o,
  output logic              pend_o
);
  logic       st_wr;
  logic [1:0] code;
  logic       pend_q, pend_d;

  assign st_wr  = we_i && (waddr_i == ADDR_W'(ADDR_STATE));
  assign srst_o = we_i && (waddr_i == ADDR_W'(ADDR_SRST)) && wdata_i[0];
  assign code   = wdata_i[1:0];

  always_comb begin
    start_o   = 1'b0;
    target_o  = run_state_e'(code);
    illegal_o = 1'b0;
    pend_d    = pend_q;
    if (st_wr && !valid_i) begin
      illegal_o = 1'b1;
    end else if (st_wr) begin
      pend_d = 1'b0;
      if (cur_state_i == ST_PAUSE) begin
        if (code == ST_CLEAR) begin
          if (pend_q) begin
            start_o  = 1'b1;
            target_o = ST_RESET;
          end else begin
            pend_d = 1'b1;
          end
        end else if (code != ST_RESET) begin
          start_o = 1'b1;
        end
      end else if (code != ST_CLEAR) begin
        start_o = 1'b1;
      end
    end
    if (srst_o) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R5
  pend_in_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (cur_state_i == ST_PAUSE));
  // R4
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && st_wr) |=> $stable(pend_q));
endmodule

// File: rtl/rs_run_sequencer.sv
module rs_run_sequencer
  import rs_pkg::*;
#(
  parameter int SETTLE_W   = 8,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_STATE = 0,
  parameter int ADDR_SRST  = 1,
  parameter int ADDR_STAT  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_waddr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic [ADDR_W-1:0]   reg_raddr_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [1:0]          state_o,
  output logic                valid_o,
  output logic                dp_en_o,
  output logic                flush_o
);
  localparam int VALID_BIT = 2;

  run_state_e state_q, target_q, target_d;
  logic start, illegal, srst, pend, busy, done;
  logic ill_q, flush_q;

  rs_req_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_STATE(ADDR_STATE), .ADDR_SRST(ADDR_SRST)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .waddr_i(reg_waddr_i),
    .wdata_i(reg_wdata_i), .valid_i(valid_o), .cur_state_i(state_q),
    .start_o(start), .target_o(target_d), .illegal_o(illegal),
    .srst_o(srst), .pend_o(pend)
  );

  rs_settle_timer #(.CNT_W(SETTLE_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .abort_i(srst),
    .len_i(settle_i), .busy_o(busy), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RESET;
      target_q <= ST_RESET;
      ill_q    <= 1'b0;
      flush_q  <= 1'b0;
    end else if (srst) begin
      state_q  <= ST_RESET;
      ill_q    <= 1'b0;
      flush_q  <= 1'b1;
    end else begin
      flush_q <= 1'b0;
      if (illegal) ill_q <= 1'b1;
      if (start) target_q <= target_d;
      if (done) begin
        state_q <= target_q;
        flush_q <= (target_q == ST_RESET);
      end
    end
  end

  assign state_o = state_q;
  assign valid_o = !busy;
  assign dp_en_o = (state_q == ST_RUN) && !busy;
  assign flush_o = flush_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_raddr_i == ADDR_W'(ADDR_STATE)) begin
      reg_rdata_o[1:0]       = state_q;
      reg_rdata_o[VALID_BIT] = valid_o;
    end else if (reg_raddr_i == ADDR_W'(ADDR_STAT)) begin
      reg_rdata_o[0] = ill_q;
      reg_rdata_o[1] = pend;
    end
  end

  // R3
  start_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !srst) |=> !valid_o);
  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done && !srst) |=> $stable(state_q));
  // R4
  ill_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ill_q && !srst) |=> ill_q);
  // R8
  srst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (state_o == ST_RESET && valid_o && !ill_q && !pend));
  // R9
  flush_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (state_o == ST_RESET));
  // R10
  dp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !srst) |=> !dp_en_o);
endmodule

// File: tb/rs_run_sequencer_tb.sv
module rs_run_sequencer_tb;
  localparam int SW = 4;
  localparam int AW = 2;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni;
  logic [SW-1:0] settle;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;
  logic [1:0]    st;
  logic          vld, dpen, fl;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  int m_state, m_valid, m_cnt, m_tgt, m_pend, m_ill, m_flush;

  rs_run_sequencer #(.SETTLE_W(SW), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .settle_i(settle), .reg_we_i(we),
    .reg_waddr_i(waddr), .reg_wdata_i(wdata), .reg_raddr_i(raddr),
    .reg_rdata_o(rdata), .state_o(st), .valid_o(vld), .dp_en_o(dpen),
    .flush_o(fl)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    case (a)
      2'd0:    return 32'(m_state) | (32'(m_valid) << 2);
      2'd2:    return 32'(m_ill) | (32'(m_pend) << 1);
      default: return 32'd0;
    endcase
  endfunction

  task automatic mstart(int c);
    m_cnt   = (settle == 0) ? 1 : int'(settle);
    m_tgt   = c;
    m_valid = 0;
    m_pend  = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_state = 0; m_valid = 1; m_cnt = 0; m_tgt = 0;
      m_pend = 0; m_ill = 0; m_flush = 0;
    end else begin
      int os, ov, op, code;
      os = m_state; ov = m_valid; op = m_pend; code = int'(wdata[1:0]);
      m_flush = 0;
      if (we && waddr == 2'd1 && wdata[0]) begin
        m_state = 0; m_valid = 1; m_cnt = 0; m_pend = 0; m_ill = 0; m_flush = 1;
      end else begin
        if (m_cnt > 0) begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_state = m_tgt; m_valid = 1; m_flush = (m_tgt == 0);
          end
        end
        if (we && waddr == 2'd0) begin
          if (ov == 0) m_ill = 1;
          else if (os == 3) begin
            if (code == 2) begin
              if (op != 0) mstart(0);
              else m_pend = 1;
            end else if (code == 0) m_pend = 0;
            else mstart(code);
          end else begin
            m_pend = 0;
            if (code != 2) mstart(code);
          end
        end
      end
    end
    #2;
    if (rst_ni && !ended) begin
      chk("R3", "state", 32'(st), 32'(m_state));
      chk("R3", "valid", 32'(vld), 32'(m_valid));
      chk("R10", "dp_en", 32'(dpen), 32'(m_state == 1 && m_valid == 1));
      chk("R9", "flush", 32'(fl), 32'(m_flush));
      chk("R2", "rdata", rdata, exp_rd(raddr));
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 64 && !vld; i++) @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    raddr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] r;
    rst_ni = 1'b0; settle = 4'd3; we = 1'b0; waddr = '0; wdata = '0; raddr = '0;
    idle(3);
    rst_ni = 1'b1;
    // R1
    chk("R1", "state", 32'(st), 0);
    chk("R1", "valid", 32'(vld), 1);
    chk("R1", "dp_en", 32'(dpen), 0);
    chk("R1", "flush", 32'(fl), 0);
    rd(2, r); chk("R1", "status", r, 0);
    idle(1);

    // R3 settle timing to run
    wr(0, 1);
    chk("R3", "valid low", 32'(vld), 0);
    idle(2); chk("R3", "still low", 32'(vld), 0);
    chk("R3", "old state", 32'(st), 0);
    idle(1); chk("R3", "valid up", 32'(vld), 1);
    chk("R3", "run", 32'(st), 1);
    chk("R10", "dp_en run", 32'(dpen), 1);

    // R4 write while settling
    wr(0, 3);
    wr(0, 1);
    rd(2, r); chk("R4", "illegal flag", r & 1, 1);
    wait_valid();
    chk("R4", "ignored", 32'(st), 3);

    // R5 double clear from pause
    wr(0, 2);
    chk("R5", "first clear state", 32'(st), 3);
    chk("R5", "first clear valid", 32'(vld), 1);
    rd(2, r); chk("R5", "pending", (r >> 1) & 1, 1);
    wr(0, 2);
    wait_valid();
    chk("R5", "reset", 32'(st), 0);
    rd(2, r); chk("R5", "pending cleared", (r >> 1) & 1, 0);

    // R6 cancel paths
    wr(0, 1); wait_valid(); wr(0, 3); wait_valid();
    wr(0, 2); wr(0, 0);
    chk("R6", "zero refused", 32'(st), 3);
    chk("R6", "valid kept", 32'(vld), 1);
    rd(2, r); chk("R6", "cancel", (r >> 1) & 1, 0);
    wr(0, 2); wr(0, 1);
    rd(2, r); chk("R6", "cancel on run", (r >> 1) & 1, 0);
    wait_valid();
    chk("R6", "to run", 32'(st), 1);

    // R7 clear code outside pause
    wr(0, 2);
    chk("R7", "no change", 32'(st), 1);
    chk("R7", "valid", 32'(vld), 1);

    // R11 zero settle
    settle = 4'd0;
    wr(0, 3);
    chk("R11", "one low", 32'(vld), 0);
    idle(1);
    chk("R11", "up", 32'(vld), 1);
    chk("R11", "pause", 32'(st), 3);

    // R8 soft reset during long settle
    settle = 4'd15;
    wr(0, 1);
    idle(4);
    wr(1, 1);
    chk("R8", "state", 32'(st), 0);
    chk("R8", "valid", 32'(vld), 1);
    rd(2, r); chk("R8", "status", r, 0);
    idle(20);
    chk("R8", "abort held", 32'(st), 0);
    settle = 4'd2;
    wr(0, 1); wait_valid();
    wr(1, 0);
    chk("R8", "bit0 zero", 32'(st), 1);
    wr(0, 0); wait_valid();
    chk("R9", "run to reset", 32'(st), 0);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      settle = SW'($urandom_range(0, 3));
      raddr  = AW'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) begin
        we = 1'b1;
        waddr = AW'($urandom_range(0, 4) == 0 ? 1 : 0);
        wdata = DW'($urandom_range(0, 3));
      end else begin
        we = 1'b0;
      end
      @(negedge clk);
    end
    we = 1'b0;
    idle(8);
    finish_run();
  end
endmodule